// File: doc/BRIEF.md
# ID-Qualified Transaction Event Filter

This block sits between a memory controller's transaction monitor and a bank of event counters. It watches the read and write transaction channels and checks each transaction's 16-bit bus ID against one shared filter word. It then tells each counter lane whether the lane should advance. Each lane selects an event code. Code 0x41 follows filtered reads and code 0x42 follows filtered writes. Every other code never receives an increment from this block, because those events come from elsewhere.

The filter word is written as one 32-bit value. Bits 15:0 hold the reference ID. Bits 31:16 hold a compare mask that is stored inverted relative to the mask a user thinks in: a stored 1 means the matching ID bit takes part in the comparison. Software therefore flips the upper half of its word before writing it. After reset the stored mask is all zeros, so every ID matches. In the byte-counting build, a lane that advances also receives the transfer's byte count, so that the counter behind it can keep a byte total next to its burst count.

Top module: `axid_filt_qual`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `lane_hit` and `lane_bytes` are zero. The filter word resets to 0x0000_0000, which compares no ID bits, so every ID matches.
- R2: A transaction matches when `((id ^ flt[15:0]) & flt[31:16]) == 0`. A 1 in bits 31:16 of the stored word enables the comparison of that ID bit.
- R3: A lane whose code is 0x41 is advanced only by a valid, matching read. A lane whose code is 0x42 is advanced only by a valid, matching write. A lane with any other code never has its `lane_hit` bit set.
- R4: `lane_hit[n]` is high in the cycle after the clock edge that sampled the qualifying transaction, and for that one cycle only. Each transaction gives at most one pulse per lane.
- R5: A filter write and a transaction in the same cycle are matched against the filter value held before the write. Transactions from the next cycle on use the new 32-bit value, taken as a whole.
- R6: The read and write channels are qualified independently. A matching read and a matching write in the same cycle advance their 0x41 lanes and their 0x42 lanes together.
- R7: All lanes use the same filter word. Two lanes that select the same code always pulse together.
- R8: When `lane_hit[n]` is high, `lane_bytes[n]` carries the byte count of the transaction that caused it (read or write bytes, according to the lane's code). Otherwise `lane_bytes[n]` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_we | input | 1 | Filter word write strobe |
| flt_wdata | input | 32 | Stored filter word: mask (stored form) in 31:16, ID in 15:0 |
| rd_vld | input | 1 | Read transaction valid |
| rd_id | input | 16 | Read transaction ID |
| rd_bytes | input | BYTE_W | Read transfer size in bytes |
| wr_vld | input | 1 | Write transaction valid |
| wr_id | input | 16 | Write transaction ID |
| wr_bytes | input | BYTE_W | Write transfer size in bytes |
| lane_code | input | NCNT*8 | Event code per lane, lane n in bits 8n+7:8n |
| lane_hit | output | NCNT | Per-lane increment pulse |
| lane_bytes | output | NCNT*BYTE_W | Per-lane byte increment, lane n in bits BYTE_W*n+BYTE_W-1:BYTE_W*n |

## Verification
Two kinds of event can land in the same cycle. The first is a read match and a write match. The second is a filter write and a transaction that it would change the outcome of. The bench drives both channels valid, with IDs that match, in the same cycle. It checks that the 0x41 lanes and the 0x42 lanes pulse together, each with its own byte count. It also writes a new filter word in the cycle of a transaction that only the old word matches, and then repeats that transaction one cycle later. The pulse is expected for the first transaction and not for the second. A behavioural model of the filter, updated after each edge, judges every cycle.

// File: rtl/axidq_pkg.sv
package axidq_pkg;
  localparam logic [7:0] CODE_RD = 8'h41;
  localparam logic [7:0] CODE_WR = 8'h42;
  localparam int unsigned ID_W = 16;

  typedef struct packed {
    logic [ID_W-1:0] cmp_mask;  // 1 = compare this ID bit
    logic [ID_W-1:0] ref_id;
  } flt_word_t;
endpackage

// File: rtl/axidq_flt_reg.sv
module axidq_flt_reg
  import axidq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  logic [31:0] wdata,
  output flt_word_t flt
);
  flt_word_t flt_d;
  flt_word_t flt_q;

  always_comb begin
    flt_d = flt_q;
    if (we) flt_d = flt_word_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flt_q <= '0;
    else        flt_q <= flt_d;
  end

  assign flt = flt_q;
endmodule

// File: rtl/axidq_match.sv
module axidq_match
  import axidq_pkg::*;
(
  input  logic            vld,
  input  logic [ID_W-1:0] id,
  input  flt_word_t       flt,
  output logic            hit
);
  logic [ID_W-1:0] diff;

  always_comb begin
    diff = (id ^ flt.ref_id) & flt.cmp_mask;
    hit  = vld && (diff == '0);
  end
endmodule

// File: rtl/axidq_lane.sv
module axidq_lane
  import axidq_pkg::*;
#(
  parameter int unsigned BYTE_W = 12,
  parameter bit          ENH    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        code,
  input  logic              rd_m,
  input  logic              wr_m,
  input  logic [BYTE_W-1:0] rd_bytes,
  input  logic [BYTE_W-1:0] wr_bytes,
  output logic              hit,
  output logic [BYTE_W-1:0] bytes
);
  logic sel_rd, sel_wr;
  logic hit_d, hit_q;

  always_comb begin
    sel_rd = (code == CODE_RD) && rd_m;
    sel_wr = (code == CODE_WR) && wr_m;
    hit_d  = sel_rd || sel_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end
  assign hit = hit_q;

  generate
    if (ENH) begin : g_bytes
      logic [BYTE_W-1:0] bytes_d, bytes_q;
      always_comb begin
        bytes_d = '0;
        if (sel_rd)      bytes_d = rd_bytes;
        else if (sel_wr) bytes_d = wr_bytes;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bytes_q <= '0;
        else        bytes_q <= bytes_d;
      end
      assign bytes = bytes_q;
    end else begin : g_nobytes
      assign bytes = '0;
    end
  endgenerate
endmodule

// File: rtl/axid_filt_qual.sv
module axid_filt_qual
  import axidq_pkg::*;
#(
  parameter int unsigned NCNT   = 4,
  parameter int unsigned BYTE_W = 12,
  parameter bit          ENH    = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flt_we,
  input  logic [31:0]            flt_wdata,
  input  logic                   rd_vld,
  input  logic [15:0]            rd_id,
  input  logic [BYTE_W-1:0]      rd_bytes,
  input  logic                   wr_vld,
  input  logic [15:0]            wr_id,
  input  logic [BYTE_W-1:0]      wr_bytes,
  input  logic [NCNT*8-1:0]      lane_code,
  output logic [NCNT-1:0]        lane_hit,
  output logic [NCNT*BYTE_W-1:0] lane_bytes
);
  flt_word_t flt;
  logic      rd_m, wr_m;

  axidq_flt_reg u_flt (
    .clk(clk), .rst_n(rst_n), .we(flt_we), .wdata(flt_wdata), .flt(flt)
  );

  axidq_match u_rd_match (.vld(rd_vld), .id(rd_id), .flt(flt), .hit(rd_m));
  axidq_match u_wr_match (.vld(wr_vld), .id(wr_id), .flt(flt), .hit(wr_m));

  generate
    for (genvar n = 0; n < NCNT; n++) begin : g_lane
      axidq_lane #(.BYTE_W(BYTE_W), .ENH(ENH)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .code     (lane_code[n*8 +: 8]),
        .rd_m     (rd_m),
        .wr_m     (wr_m),
        .rd_bytes (rd_bytes),
        .wr_bytes (wr_bytes),
        .hit      (lane_hit[n]),
        .bytes    (lane_bytes[n*BYTE_W +: BYTE_W])
      );
    end
  endgenerate
endmodule

// File: rtl/axidq_chk.sv
module axidq_chk #(
  parameter int unsigned NCNT   = 4,
  parameter int unsigned BYTE_W = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rd_vld,
  input logic                   wr_vld,
  input logic [BYTE_W-1:0]      rd_bytes,
  input logic [BYTE_W-1:0]      wr_bytes,
  input logic [NCNT*8-1:0]      lane_code,
  input logic [NCNT-1:0]        lane_hit,
  input logic [NCNT*BYTE_W-1:0] lane_bytes
);
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_vld && !wr_vld) |=> (lane_hit == '0));  // R4

  for (genvar n = 0; n < NCNT; n++) begin : g_c
    AST_OTHER_CODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_code[n*8 +: 8] != 8'h41 && lane_code[n*8 +: 8] != 8'h42) |=> !lane_hit[n]);  // R3
    AST_RD_LANE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_code[n*8 +: 8] == 8'h41 && !rd_vld) |=> !lane_hit[n]);  // R3
    AST_WR_LANE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_code[n*8 +: 8] == 8'h42 && !wr_vld) |=> !lane_hit[n]);  // R3
    AST_BYTES_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_hit[n] |-> (lane_bytes[n*BYTE_W +: BYTE_W] == '0));  // R8
    AST_RD_BYTES_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_code[n*8 +: 8] == 8'h41) |=> (!lane_hit[n] || lane_bytes[n*BYTE_W +: BYTE_W] == $past(rd_bytes)));  // R8
    AST_WR_BYTES_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_code[n*8 +: 8] == 8'h42) |=> (!lane_hit[n] || lane_bytes[n*BYTE_W +: BYTE_W] == $past(wr_bytes)));  // R8
  end
endmodule

bind axid_filt_qual axidq_chk #(.NCNT(NCNT), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .wr_vld(wr_vld),
  .rd_bytes(rd_bytes), .wr_bytes(wr_bytes), .lane_code(lane_code),
  .lane_hit(lane_hit), .lane_bytes(lane_bytes)
);

// File: tb/test_axid_filt_qual.sv
`timescale 1ns/1ps
module test_axid_filt_qual;
  localparam int NCNT = 4;
  localparam int BW   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flt_we = 1'b0;
  logic [31:0] flt_wdata = '0;
  logic rd_vld = 1'b0, wr_vld = 1'b0;
  logic [15:0] rd_id = '0, wr_id = '0;
  logic [BW-1:0] rd_bytes = '0, wr_bytes = '0;
  logic [NCNT*8-1:0] lane_code = '0;
  logic [NCNT-1:0] lane_hit;
  logic [NCNT*BW-1:0] lane_bytes;

  axid_filt_qual #(.NCNT(NCNT), .BYTE_W(BW), .ENH(1'b1)) i_axid_filt_qual (
    .clk(clk), .rst_n(rst_n), .flt_we(flt_we), .flt_wdata(flt_wdata),
    .rd_vld(rd_vld), .rd_id(rd_id), .rd_bytes(rd_bytes),
    .wr_vld(wr_vld), .wr_id(wr_id), .wr_bytes(wr_bytes),
    .lane_code(lane_code), .lane_hit(lane_hit), .lane_bytes(lane_bytes)
  );

  always #10 clk = ~clk;  // 50 MHz

  int compared = 0, mismatched = 0;
  string cur_req = "R1";
  logic [31:0] m_flt = '0;
  logic [NCNT-1:0] exp_hit = '0;
  logic [NCNT*BW-1:0] exp_bytes = '0;

  function automatic bit id_ok(logic [15:0] id, logic [31:0] f);
    return ((id ^ f[15:0]) & f[31:16]) == 16'h0;
  endfunction

  // model update at each edge, from inputs driven at the previous negedge
  task automatic tick();
    @(posedge clk);
    if (!rst_n) begin
      exp_hit = '0; exp_bytes = '0; m_flt = '0;
    end else begin
      bit rm = rd_vld && id_ok(rd_id, m_flt);
      bit wm = wr_vld && id_ok(wr_id, m_flt);
      for (int n = 0; n < NCNT; n++) begin
        logic [7:0] c = lane_code[n*8 +: 8];
        exp_hit[n] = 1'b0;
        exp_bytes[n*BW +: BW] = '0;
        if (c == 8'h41 && rm) begin exp_hit[n] = 1'b1; exp_bytes[n*BW +: BW] = rd_bytes; end
        if (c == 8'h42 && wm) begin exp_hit[n] = 1'b1; exp_bytes[n*BW +: BW] = wr_bytes; end
      end
      if (flt_we) m_flt = flt_wdata;
    end
    @(negedge clk);
    compared++;
    if (lane_hit !== exp_hit || lane_bytes !== exp_bytes) begin
      mismatched++;
      $display("FAIL %s: hit=%b bytes=%h expected hit=%b bytes=%h",
               cur_req, lane_hit, lane_bytes, exp_hit, exp_bytes);
    end
  endtask

  task automatic idle();
    rd_vld = 0; wr_vld = 0; flt_we = 0;
  endtask

  task automatic set_codes(logic [7:0] c0, logic [7:0] c1, logic [7:0] c2, logic [7:0] c3);
    lane_code = {c3, c2, c1, c0};
  endtask

  task automatic rd(logic [15:0] id, logic [BW-1:0] b);
    rd_vld = 1; rd_id = id; rd_bytes = b;
  endtask

  task automatic wr(logic [15:0] id, logic [BW-1:0] b);
    wr_vld = 1; wr_id = id; wr_bytes = b;
  endtask

  initial begin
    #4000000;
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1 reset state
    cur_req = "R1";
    set_codes(8'h41, 8'h42, 8'h41, 8'h00);
    rd(16'hBEEF, 12'h010); wr(16'h1234, 12'h020);
    repeat (3) tick();
    @(negedge clk); rst_n = 1;
    idle(); tick();
    // R1 match-all default filter
    rd(16'hBEEF, 12'h040); tick(); idle(); tick();

    // R2 mask rule: compare upper byte only (stored mask 0xFF00)
    cur_req = "R2";
    flt_we = 1; flt_wdata = 32'hFF00_1234; tick(); idle();
    rd(16'h12AB, 12'h008); tick();
    rd(16'h1334, 12'h008); tick();
    wr(16'h12FF, 12'h100); tick();
    wr(16'h0234, 12'h100); tick(); idle(); tick();

    // R3 code selectivity
    cur_req = "R3";
    set_codes(8'h41, 8'h42, 8'h04, 8'h05);
    rd(16'h1200, 12'h004); tick(); idle();
    wr(16'h1200, 12'h004); tick(); idle(); tick();

    // R5 filter write in the same cycle as a transaction
    cur_req = "R5";
    set_codes(8'h41, 8'h41, 8'h42, 8'h42);
    flt_we = 1; flt_wdata = 32'hFFFF_5555;
    rd(16'h1299, 12'h0AA); tick(); flt_we = 0;
    rd(16'h1299, 12'h0AA); tick();
    rd(16'h5555, 12'h0AB); tick(); idle(); tick();

    // R6 read and write matches in the same cycle
    cur_req = "R6";
    rd(16'h5555, 12'h111); wr(16'h5555, 12'h222); tick();
    rd(16'h5555, 12'h333); wr(16'h0000, 12'h444); tick(); idle(); tick();

    // R7 shared filter across all lanes
    cur_req = "R7";
    set_codes(8'h41, 8'h41, 8'h41, 8'h41);
    rd(16'h5555, 12'h00F); tick();
    rd(16'h5554, 12'h00F); tick(); idle(); tick();

    // R8 byte counts incl. maximum
    cur_req = "R8";
    set_codes(8'h41, 8'h42, 8'h00, 8'h42);
    flt_we = 1; flt_wdata = 32'h0000_0000; tick(); flt_we = 0;
    rd(16'hAAAA, 12'hFFF); wr(16'h0001, 12'h001); tick();
    rd(16'h0000, 12'h000); wr(16'hFFFF, 12'hFFF); tick(); idle(); tick();

    // R4 randomized traffic, one pulse per transaction
    cur_req = "R4";
    flt_we = 1; flt_wdata = 32'hC000_4000; tick(); flt_we = 0;
    for (int k = 0; k < 400; k++) begin
      rd_vld = 1'($urandom_range(0, 1)); rd_id = 16'($urandom); rd_bytes = BW'($urandom);
      wr_vld = 1'($urandom_range(0, 1)); wr_id = 16'($urandom); wr_bytes = BW'($urandom);
      if ($urandom_range(0, 19) == 0) begin
        flt_we = 1; flt_wdata = {2'($urandom), 14'h0, 16'($urandom)};
      end else flt_we = 0;
      if ($urandom_range(0, 15) == 0)
        lane_code = {8'($urandom_range(64, 67)), 8'($urandom_range(64, 67)),
                     8'($urandom_range(64, 67)), 8'($urandom_range(64, 67))};
      tick();
    end
    idle(); tick(); tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule